// File: doc/BRIEF.md
# LUT-Fed Arithmetic Register Slice

This block is a column of bit cells that together form one wide arithmetic register. Every cell holds two programmable four-input lookup functions. Both functions see the same four data inputs of that cell, and each is defined by a 16-bit truth-table mask. A dedicated full adder in the cell adds the two lookup results. The carry ripples straight from each cell's adder into the next cell's adder, so the slice as a whole computes a multi-bit sum or difference of the two lookup-function vectors. That result is captured in a bank of registers, one register per cell.

The same adder chain also serves as an up/down counter on the registered value. Slice-wide controls select add or subtract, count direction, counter enable and clock enable, and also drive a synchronous clear and a synchronous load. Per-register mask bits decide whether each register responds to the shared clear and to the shared load. A register that ignores an active clear or load takes the ordinary update instead. Each cell also brings out the first lookup function's result as a combinational output. That output stays usable while the cell's adder keeps carrying for the cells above it; the cell's own sum is then simply left unused.

The update chosen for each register on a clock edge is one of five named kinds. UPD_HOLD applies when the clock enable is low. UPD_CLEAR applies when the clear is active and the register obeys it. UPD_LOAD applies when the load is active, the register obeys it and no clear was taken. UPD_COUNT applies when the counter enable is high. UPD_ARITH applies otherwise. The slice has no sequential state beyond the registers themselves.

Top module: `lutarith_slice`

## Requirements
- R1: Each cell's lut_out equals bit k of that cell's first mask (lut_a_mask bits [16*i+15:16*i] for cell i), where k is the cell's four data inputs cell_in[4*i+3:4*i] read as an unsigned number. The output is combinational.
- R2: With ce high, cnt_en, sclr and sload low and sub_mode low, q takes A+B modulo 2^N on the next edge. A is the vector of first-function results and B the vector of second-function results, with cell 0 as the least significant bit. carry_out meanwhile shows the carry out of the top cell, which is bit N of A+B.
- R3: With sub_mode high under the conditions of R2, q takes A-B modulo 2^N. carry_out is 1 exactly when A >= B, meaning the adder sees inverted B plus a carry-in of 1.
- R4: With ce and cnt_en high and sclr and sload low, q increments by one when cnt_down is 0 and decrements by one when cnt_down is 1, wrapping modulo 2^N. sub_mode has no effect in this case.
- R5: While counting, carry_out shows the carry of the counting add. Counting up, it is 1 only when q is all ones. Counting down (adding all ones), it is 1 unless q is zero.
- R6: With ce low, q holds its value whatever the other controls do.
- R7: With ce and sclr high, every register whose clr_use bit is set becomes 0. Clear wins over load for such registers.
- R8: With ce and sload high, every register whose load_use bit is set and that is not being cleared takes its load_val bit. Load wins over counting and arithmetic.
- R9: A register whose use bit is clear ignores an active sclr or sload and takes the count or arithmetic update instead.
- R10: While rst_n is low, q is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the registers |
| lut_a_mask | input | 16*N | Truth tables of the first lookup function, 16 bits per cell |
| lut_b_mask | input | 16*N | Truth tables of the second lookup function, 16 bits per cell |
| cell_in | input | 4*N | Four data inputs per cell, shared by both of its functions |
| load_val | input | N | Value for synchronous load |
| clr_use | input | N | Per-register enable for the shared clear |
| load_use | input | N | Per-register enable for the shared load |
| ce | input | 1 | Clock enable for every register update |
| cnt_en | input | 1 | Counter enable: counts instead of registering A±B |
| cnt_down | input | 1 | Count direction, 1 = down |
| sub_mode | input | 1 | 1 = subtract B from A |
| sclr | input | 1 | Slice-wide synchronous clear |
| sload | input | 1 | Slice-wide synchronous load |
| q | output | N | Registered outputs |
| lut_out | output | N | Combinational first-function result per cell |
| carry_out | output | 1 | Carry out of the top cell's adder |

## Verification
The assertions assume that every control, mask and data input is at a known 0 or 1 at each rising clock edge, and that rst_n is released only while the controls are steady. The clear, load, hold and count properties compare q with values captured one edge earlier, so they also assume that every sampled input is defined throughout the run. The bench meets this by driving every input to a defined level before reset is released. It changes inputs only on falling edges and gives every random mask, data pattern and control a full value before the next rising edge.

// File: rtl/lutarith_pkg.sv
package lutarith_pkg;
    typedef enum logic [2:0] {
        UPD_HOLD  = 3'd0,
        UPD_CLEAR = 3'd1,
        UPD_LOAD  = 3'd2,
        UPD_COUNT = 3'd3,
        UPD_ARITH = 3'd4
    } upd_e;

    localparam int unsigned LUT_INPUTS = 4;
    localparam int unsigned LUT_SIZE   = 1 << LUT_INPUTS;
endpackage

// File: rtl/lutarith_lut4.sv
module lutarith_lut4
    import lutarith_pkg::*;
(
    input  logic [LUT_SIZE-1:0]   mask,
    input  logic [LUT_INPUTS-1:0] sel,
    output logic                  f
);
    always_comb begin
        f = mask[sel];
    end
endmodule

// File: rtl/lutarith_chain.sv
module lutarith_chain #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] opx,
    input  logic [N-1:0] opy,
    input  logic         invert_y,
    output logic [N-1:0] sum,
    output logic         cout
);
    logic [N:0]   carry;
    logic [N-1:0] yeff;

    assign yeff     = invert_y ? ~opy : opy;
    assign carry[0] = invert_y;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign sum[i]     = opx[i] ^ yeff[i] ^ carry[i];
        assign carry[i+1] = (opx[i] & yeff[i]) | (carry[i] & (opx[i] ^ yeff[i]));
    end

    assign cout = carry[N];

    // Ripple chain must agree with a wide add (R2, R3, R5)
    assert_chain_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {cout, sum} == ({1'b0, opx} + {1'b0, yeff} + {{N{1'b0}}, invert_y}));
endmodule

// File: rtl/lutarith_ctrl.sv
module lutarith_ctrl
    import lutarith_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         cnt_en,
    input  logic         sclr,
    input  logic         sload,
    input  logic [N-1:0] clr_use,
    input  logic [N-1:0] load_use,
    output upd_e         base_kind,
    output logic [N-1:0] clr_hit,
    output logic [N-1:0] ld_hit
);
    always_comb begin
        unique case ({ce, cnt_en})
            2'b10:   base_kind = UPD_ARITH;
            2'b11:   base_kind = UPD_COUNT;
            default: base_kind = UPD_HOLD;
        endcase
    end

    always_comb begin
        clr_hit = {N{ce & sclr}} & clr_use;
        ld_hit  = {N{ce & sload}} & load_use & ~clr_hit;
    end

    // No clear or load may be taken without the clock enable (R6)
    assert_no_hit_without_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> (clr_hit == '0 && ld_hit == '0 && base_kind == UPD_HOLD));
endmodule

// File: rtl/lutarith_regs.sv
module lutarith_regs
    import lutarith_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  upd_e         base_kind,
    input  logic [N-1:0] clr_hit,
    input  logic [N-1:0] ld_hit,
    input  logic [N-1:0] load_val,
    input  logic [N-1:0] adder_sum,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        upd_e kind;

        always_comb begin
            if (clr_hit[i])      kind = UPD_CLEAR;
            else if (ld_hit[i])  kind = UPD_LOAD;
            else                 kind = base_kind;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                unique case (kind)
                    UPD_CLEAR: q[i] <= 1'b0;
                    UPD_LOAD:  q[i] <= load_val[i];
                    UPD_COUNT,
                    UPD_ARITH: q[i] <= adder_sum[i];
                    default:   q[i] <= q[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/lutarith_slice.sv
module lutarith_slice
    import lutarith_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N*LUT_SIZE-1:0] lut_a_mask,
    input  logic [N*LUT_SIZE-1:0] lut_b_mask,
    input  logic [N*LUT_INPUTS-1:0] cell_in,
    input  logic [N-1:0]          load_val,
    input  logic [N-1:0]          clr_use,
    input  logic [N-1:0]          load_use,
    input  logic                  ce,
    input  logic                  cnt_en,
    input  logic                  cnt_down,
    input  logic                  sub_mode,
    input  logic                  sclr,
    input  logic                  sload,
    output logic [N-1:0]          q,
    output logic [N-1:0]          lut_out,
    output logic                  carry_out
);
    localparam logic [N-1:0] STEP_ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] fa, fb;
    logic [N-1:0] opx, opy, adder_sum;
    logic         invert_y;
    upd_e         base_kind;
    logic [N-1:0] clr_hit, ld_hit;

    for (genvar i = 0; i < N; i++) begin : g_cell
        lutarith_lut4 u_lut_a (
            .mask (lut_a_mask[i*LUT_SIZE +: LUT_SIZE]),
            .sel  (cell_in[i*LUT_INPUTS +: LUT_INPUTS]),
            .f    (fa[i])
        );
        lutarith_lut4 u_lut_b (
            .mask (lut_b_mask[i*LUT_SIZE +: LUT_SIZE]),
            .sel  (cell_in[i*LUT_INPUTS +: LUT_INPUTS]),
            .f    (fb[i])
        );
    end

    assign lut_out = fa;

    // Counting feeds the register back into the adder with a step of +1 or all ones
    always_comb begin
        if (cnt_en) begin
            opx      = q;
            opy      = cnt_down ? {N{1'b1}} : STEP_ONE;
            invert_y = 1'b0;
        end else begin
            opx      = fa;
            opy      = fb;
            invert_y = sub_mode;
        end
    end

    lutarith_chain #(.N(N)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .opx      (opx),
        .opy      (opy),
        .invert_y (invert_y),
        .sum      (adder_sum),
        .cout     (carry_out)
    );

    lutarith_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .cnt_en    (cnt_en),
        .sclr      (sclr),
        .sload     (sload),
        .clr_use   (clr_use),
        .load_use  (load_use),
        .base_kind (base_kind),
        .clr_hit   (clr_hit),
        .ld_hit    (ld_hit)
    );

    lutarith_regs #(.N(N)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_kind (base_kind),
        .clr_hit   (clr_hit),
        .ld_hit    (ld_hit),
        .load_val  (load_val),
        .adder_sum (adder_sum),
        .q         (q)
    );

    // Hold when the clock enable is low (R6)
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce)) |-> $stable(q));

    // Masked clear zeroes its registers (R7)
    assert_masked_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && sclr) |=> ((q & $past(clr_use)) == '0));

    // Masked load copies load_val into registers not being cleared (R8)
    assert_masked_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && sload) |=> (((q ^ $past(load_val)) &
                            $past(load_use & ~(sclr ? clr_use : '0))) == '0));

    // Plain counting steps by exactly one (R4)
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && cnt_en && !sclr && !sload) |=>
            (q == ($past(cnt_down) ? $past(q) - STEP_ONE : $past(q) + STEP_ONE)));

    // Registers are zero while reset is asserted (R10)
    always_comb begin
        if (!rst_n) assert_reset_zero_R10: assert (q == '0);
    end
endmodule

// File: tb/lutarith_slice_tb.sv
module lutarith_slice_tb;
    localparam int N = 8;
    localparam int W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N*W-1:0]   lut_a_mask = '0, lut_b_mask = '0;
    logic [N*4-1:0]   cell_in = '0;
    logic [N-1:0]     load_val = '0, clr_use = '0, load_use = '0;
    logic             ce = 1'b0, cnt_en = 1'b0, cnt_down = 1'b0;
    logic             sub_mode = 1'b0, sclr = 1'b0, sload = 1'b0;
    logic [N-1:0]     q, lut_out;
    logic             carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    lutarith_slice #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .lut_a_mask(lut_a_mask), .lut_b_mask(lut_b_mask),
        .cell_in(cell_in), .load_val(load_val), .clr_use(clr_use), .load_use(load_use),
        .ce(ce), .cnt_en(cnt_en), .cnt_down(cnt_down), .sub_mode(sub_mode),
        .sclr(sclr), .sload(sload), .q(q), .lut_out(lut_out), .carry_out(carry_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] eval_luts(input logic [N*W-1:0] m, input logic [N*4-1:0] d);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = m[i*W + d[i*4 +: 4]];
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic randomize_cells();
        for (int i = 0; i < N; i++) begin
            lut_a_mask[i*W +: W] = W'($urandom);
            lut_b_mask[i*W +: W] = W'($urandom);
            cell_in[i*4 +: 4]    = 4'($urandom);
        end
    endtask

    task automatic idle_controls();
        ce = 0; cnt_en = 0; cnt_down = 0; sub_mode = 0; sclr = 0; sload = 0;
        clr_use = '0; load_use = '0;
    endtask

    task automatic load_q(input logic [N-1:0] v);
        idle_controls();
        ce = 1; sload = 1; load_use = '1; load_val = v;
        tick();
        idle_controls();
    endtask

    task automatic test_reset();
        check("R10 reset q", 32'(q), 32'h0);
    endtask

    task automatic test_lut();
        for (int t = 0; t < 6; t++) begin
            randomize_cells();
            #1;
            check("R1 lut_out", 32'(lut_out), 32'(eval_luts(lut_a_mask, cell_in)));
        end
    endtask

    task automatic test_add();
        for (int t = 0; t < 6; t++) begin
            logic [N:0] s;
            idle_controls();
            randomize_cells();
            ce = 1;
            s = {1'b0, eval_luts(lut_a_mask, cell_in)} + {1'b0, eval_luts(lut_b_mask, cell_in)};
            #1;
            check("R2 carry_out", 32'(carry_out), 32'(s[N]));
            tick();
            check("R2 sum in q", 32'(q), 32'(s[N-1:0]));
        end
    endtask

    task automatic test_sub();
        for (int t = 0; t < 6; t++) begin
            logic [N-1:0] a, b;
            idle_controls();
            randomize_cells();
            ce = 1; sub_mode = 1;
            a = eval_luts(lut_a_mask, cell_in);
            b = eval_luts(lut_b_mask, cell_in);
            #1;
            check("R3 no-borrow carry", 32'(carry_out), 32'(a >= b));
            tick();
            check("R3 difference in q", 32'(q), 32'(N'(a - b)));
        end
    endtask

    task automatic test_count();
        logic [N-1:0] e;
        e = 8'h3c;
        load_q(e);
        ce = 1; cnt_en = 1; sub_mode = 1;
        for (int t = 0; t < 5; t++) begin
            tick(); e = e + 1;
            check("R4 count up", 32'(q), 32'(e));
        end
        cnt_down = 1;
        for (int t = 0; t < 7; t++) begin
            tick(); e = e - 1;
            check("R4 count down", 32'(q), 32'(e));
        end
        idle_controls();
    endtask

    task automatic test_count_carry();
        load_q('1);
        ce = 1; cnt_en = 1; cnt_down = 0;
        #1;
        check("R5 up carry at all ones", 32'(carry_out), 32'h1);
        tick();
        check("R5 up wraps to zero", 32'(q), 32'h0);
        cnt_down = 1;
        #1;
        check("R5 down carry at zero", 32'(carry_out), 32'h0);
        tick();
        check("R5 down wraps to all ones", 32'(q), 32'hff);
        #1;
        check("R5 down carry nonzero", 32'(carry_out), 32'h1);
        idle_controls();
    endtask

    task automatic test_hold();
        load_q(8'h5a);
        randomize_cells();
        ce = 0; cnt_en = 1; sclr = 1; sload = 1;
        clr_use = '1; load_use = '1; load_val = 8'h0f;
        tick();
        check("R6 hold under ce low", 32'(q), 32'h5a);
        cnt_en = 0;
        tick();
        check("R6 hold arith ce low", 32'(q), 32'h5a);
        idle_controls();
    endtask

    task automatic test_clear();
        load_q(8'hff);
        ce = 1; sclr = 1; sload = 1; clr_use = 8'b1010_0101;
        load_use = 8'b1111_0000; load_val = 8'h00;
        cnt_en = 1; cnt_down = 1;
        tick();
        // bits 0,2,5,7 cleared; 4,6 loaded with 0; 1,3 count ff-1=fe -> bits 1,3 = 1
        check("R7 masked clear over load", 32'(q), 32'h0a);
        idle_controls();
    endtask

    task automatic test_load();
        logic [N-1:0] s;
        load_q(8'h00);
        randomize_cells();
        ce = 1; sload = 1; load_use = 8'b0011_1100; load_val = 8'hff;
        s = eval_luts(lut_a_mask, cell_in) + eval_luts(lut_b_mask, cell_in);
        tick();
        check("R8 masked load", 32'(q & 8'h3c), 32'h3c);
        check("R9 unmasked bits take sum", 32'(q & 8'hc3), 32'(s & 8'hc3));
        idle_controls();
    endtask

    task automatic test_ignore();
        load_q(8'h10);
        ce = 1; cnt_en = 1; sclr = 1; sload = 1; load_val = 8'hff;
        tick();
        check("R9 clear and load ignored", 32'(q), 32'h11);
        idle_controls();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1;
        @(negedge clk);
        test_lut();
        test_add();
        test_sub();
        test_count();
        test_count_carry();
        test_hold();
        test_clear();
        test_load();
        test_ignore();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule